// File: doc/BRIEF.md
# Trap Delivery Arbiter and Handler Vector Generator

This block takes a trap request together with the current trap level, the processor and hypervisor state words, both trap base addresses and the trap type. From these it decides how the trap is delivered. There are four delivery modes: reset-error-debug (RED), hyperprivileged, privileged, or the error condition. It then works out the fetch addresses of the handler.

The decision and the address arithmetic are combinational. Their results are captured in output registers on the clock edge that sees `trap_valid` high. The registered mode drives the mode input of the neighbouring state-save unit. The error condition is only flagged, and entering that state is left to other logic.

The block checks its cases in a fixed order of priority: RED first, then error, then guest watchdog, then hyperprivileged, then privileged. The first case that applies decides the delivery.

Top module: `trap_vector_unit`

## Requirements
- R1: While `rst` is high and after its release, until the first request, `out_valid` and `flag_error` are 0, `mode` is 0, and `eff_tt`, `new_pc`, `new_npc` and `new_nnpc` are 0.
- R2: Results appear on the clock edge after a cycle with `trap_valid` high, and `out_valid` is 1 for exactly that one cycle. In cycles without a request, all result outputs keep their values.
- R3: RED delivery (`mode`=2) is chosen when `hpstate[5]` is set or `tl` equals MAX_TL-1 (5). It overrides every other case. Its PC is 0xFFFFFFFFF00000A0, and `eff_tt` is the input trap type.
- R4: When RED is not chosen and `tl` is MAX_TL (6) or more, `mode`=3 and `flag_error`=1. In this case `new_pc`, `new_npc` and `new_nnpc` are 0, and `eff_tt` is the input trap type. `flag_error` is 0 for every other mode.
- R5: The current level is decoded from two state bits. It is user when `pstate[2]`=0, privileged when `pstate[2]`=1 and `hpstate[2]`=0, and hyperprivileged when both bits are 1.
- R6: The target level is hyperprivileged when the current level is hyperprivileged or when `hyper_trap` is 1. Otherwise the target level is privileged.
- R7: Guest watchdog case: when the target level is privileged and `tl` exceeds MAX_PTL (2), delivery is hyperprivileged (`mode`=1) with `eff_tt`=2. The PC is then the hyperprivileged vector formed with trap type 2.
- R8: Hyperprivileged delivery (`mode`=1) uses `htba` with bits 13:0 cleared, OR (trap type << 5) masked to 14 bits. `eff_tt` is the input trap type.
- R9: Privileged delivery (`mode`=0) uses `tba` with bits 14:0 cleared, OR bit 14 when `tl`+1 > 1, OR (trap type << 5) masked to 14 bits.
- R10: Whenever the mode is not error, `new_npc` = `new_pc`+4 and `new_nnpc` = `new_pc`+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request, one cycle |
| hyper_trap | input | 1 | Trap targets the hypervisor regardless of level |
| tl | input | 3 | Current trap level |
| pstate | input | 13 | Processor state word (bit 2 = privileged) |
| hpstate | input | 12 | Hypervisor state word (bit 2 = hyperprivileged, bit 5 = RED) |
| tba | input | 64 | Privileged trap base address |
| htba | input | 64 | Hyperprivileged trap base address |
| trap_type | input | 9 | Incoming trap type |
| out_valid | output | 1 | Results updated this cycle |
| mode | output | 2 | Delivery mode: 0 privileged, 1 hyper, 2 RED, 3 error |
| flag_error | output | 1 | Error condition reached |
| eff_tt | output | 9 | Trap type to record |
| new_pc | output | 64 | Handler PC |
| new_npc | output | 64 | Handler next PC |
| new_nnpc | output | 64 | Handler next-next PC |

## Verification
Every result passes through exactly one register. The bench therefore drives a request on a falling edge and samples all outputs on the following falling edge, half a cycle after the capturing rising edge. In that sample it expects `out_valid` high and the new mode, trap type and addresses. On the next falling edge, with the request dropped and the inputs changed, it expects `out_valid` low and the previous results unchanged. The expected modes and addresses come from a reference function in the bench, written from the priority order and the vector formulas.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;
  typedef enum logic [1:0] {
    MODE_PRIV  = 2'd0,
    MODE_HYPER = 2'd1,
    MODE_RED   = 2'd2,
    MODE_ERROR = 2'd3
  } deliver_mode_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_PRIV  = 2'd1,
    LVL_HYPER = 2'd2
  } priv_lvl_e;
endpackage

// File: rtl/trap_mode_arbiter.sv
module trap_mode_arbiter
  import trap_vec_pkg::*;
#(
  parameter int TL_W    = 3,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int PS_W    = 13,
  parameter int HPS_W   = 12,
  parameter int TT_W    = 9,
  parameter int WDOG_TT = 2,
  parameter int PRIV_BIT = 2,
  parameter int HPRIV_BIT = 2,
  parameter int RED_BIT = 5
) (
  input  logic [TL_W-1:0]  tl,
  input  logic [PS_W-1:0]  pstate,
  input  logic [HPS_W-1:0] hpstate,
  input  logic             hyper_trap,
  input  logic [TT_W-1:0]  trap_type,
  output deliver_mode_e    mode,
  output logic [TT_W-1:0]  eff_tt
);
  localparam logic [TL_W-1:0] RED_TL  = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] ERR_TL  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] PTL_LIM = TL_W'(MAX_PTL);

  priv_lvl_e cur_lvl;
  logic      to_hyper;
  logic      go_red, go_err, go_wdog;

  // current level from the two privilege bits
  always_comb begin
    if (!pstate[PRIV_BIT])        cur_lvl = LVL_USER;
    else if (!hpstate[HPRIV_BIT]) cur_lvl = LVL_PRIV;
    else                          cur_lvl = LVL_HYPER;
  end

  assign to_hyper = (cur_lvl == LVL_HYPER) || hyper_trap;
  assign go_red   = hpstate[RED_BIT] || (tl == RED_TL);
  assign go_err   = (tl >= ERR_TL);
  assign go_wdog  = !to_hyper && (tl > PTL_LIM);

  // fixed priority: RED, error, watchdog, hyper, privileged
  always_comb begin
    eff_tt = trap_type;
    if (go_red)         mode = MODE_RED;
    else if (go_err)    mode = MODE_ERROR;
    else if (go_wdog) begin
      mode   = MODE_HYPER;
      eff_tt = TT_W'(WDOG_TT);
    end
    else if (to_hyper)  mode = MODE_HYPER;
    else                mode = MODE_PRIV;
  end

  logic unused_state_bits;
  assign unused_state_bits = ^{pstate, hpstate};
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
  import trap_vec_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TL_W   = 3,
  parameter int TT_W   = 9,
  parameter logic [ADDR_W-1:0] RED_PC = 64'hFFFF_FFFF_F000_00A0
) (
  input  deliver_mode_e     mode,
  input  logic [TT_W-1:0]   eff_tt,
  input  logic [TL_W-1:0]   tl,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic [ADDR_W-1:0] pc_vec
);
  localparam int HOFF_W = TT_W + 5;
  localparam int POFF_W = HOFF_W + 1;

  logic [ADDR_W-1:0] hyp_vec, prv_vec;
  logic              upper_half;

  // new level is tl+1, which exceeds 1 exactly when tl is nonzero
  assign upper_half = (tl != '0);
  assign hyp_vec = {htba[ADDR_W-1:HOFF_W], eff_tt, 5'b0};
  assign prv_vec = {tba[ADDR_W-1:POFF_W], upper_half, eff_tt, 5'b0};

  always_comb begin
    unique case (mode)
      MODE_RED:   pc_vec = RED_PC;
      MODE_HYPER: pc_vec = hyp_vec;
      MODE_PRIV:  pc_vec = prv_vec;
      default:    pc_vec = '0;
    endcase
  end

  logic unused_base_bits;
  assign unused_base_bits = ^{tba[POFF_W-1:0], htba[HOFF_W-1:0]};
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_vec_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int TL_W    = 3,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int PS_W    = 13,
  parameter int HPS_W   = 12,
  parameter int TT_W    = 9,
  parameter int INSN_B  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_valid,
  input  logic              hyper_trap,
  input  logic [TL_W-1:0]   tl,
  input  logic [PS_W-1:0]   pstate,
  input  logic [HPS_W-1:0]  hpstate,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  input  logic [TT_W-1:0]   trap_type,
  output logic              out_valid,
  output logic [1:0]        mode,
  output logic              flag_error,
  output logic [TT_W-1:0]   eff_tt,
  output logic [ADDR_W-1:0] new_pc,
  output logic [ADDR_W-1:0] new_npc,
  output logic [ADDR_W-1:0] new_nnpc
);
  localparam logic [ADDR_W-1:0] RED_PC  = 64'hFFFF_FFFF_F000_00A0;
  localparam logic [ADDR_W-1:0] STEP1   = ADDR_W'(INSN_B);
  localparam logic [ADDR_W-1:0] STEP2   = ADDR_W'(2 * INSN_B);
  localparam logic [TL_W-1:0]   ERR_TL  = TL_W'(MAX_TL);

  deliver_mode_e     mode_d;
  logic [TT_W-1:0]   tt_d;
  logic [ADDR_W-1:0] pc_d;

  trap_mode_arbiter #(
    .TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL),
    .PS_W(PS_W), .HPS_W(HPS_W), .TT_W(TT_W)
  ) u_arb (
    .tl(tl), .pstate(pstate), .hpstate(hpstate), .hyper_trap(hyper_trap),
    .trap_type(trap_type), .mode(mode_d), .eff_tt(tt_d)
  );

  trap_vector_calc #(
    .ADDR_W(ADDR_W), .TL_W(TL_W), .TT_W(TT_W), .RED_PC(RED_PC)
  ) u_vec (
    .mode(mode_d), .eff_tt(tt_d), .tl(tl), .tba(tba), .htba(htba),
    .pc_vec(pc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      mode       <= 2'd0;
      flag_error <= 1'b0;
      eff_tt     <= '0;
      new_pc     <= '0;
      new_npc    <= '0;
      new_nnpc   <= '0;
    end else begin
      out_valid <= trap_valid;
      if (trap_valid) begin
        mode       <= mode_d;
        flag_error <= (mode_d == MODE_ERROR);
        eff_tt     <= tt_d;
        new_pc     <= pc_d;
        new_npc    <= (mode_d == MODE_ERROR) ? '0 : pc_d + STEP1;
        new_nnpc   <= (mode_d == MODE_ERROR) ? '0 : pc_d + STEP2;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |=> (!out_valid && $stable(new_pc) && $stable(mode))); // R2
  AST_RED_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode == 2'd2) |-> (new_pc == RED_PC)); // R3
  AST_ERROR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && !hpstate[5] && tl >= ERR_TL) |=>
      (flag_error && mode == 2'd3 && new_pc == '0)); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !flag_error) |->
      (new_npc == new_pc + STEP1 && new_nnpc == new_npc + STEP1)); // R10
endmodule

// File: tb/trap_vector_unit_bench.sv
module trap_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        trap_valid, hyper_trap;
  logic [2:0]  tl;
  logic [12:0] pstate;
  logic [11:0] hpstate;
  logic [63:0] tba, htba;
  logic [8:0]  trap_type;
  logic        out_valid, flag_error;
  logic [1:0]  mode;
  logic [8:0]  eff_tt;
  logic [63:0] new_pc, new_npc, new_nnpc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_vector_unit u_trap_vector_unit (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .hyper_trap(hyper_trap),
    .tl(tl), .pstate(pstate), .hpstate(hpstate), .tba(tba), .htba(htba),
    .trap_type(trap_type), .out_valid(out_valid), .mode(mode),
    .flag_error(flag_error), .eff_tt(eff_tt), .new_pc(new_pc),
    .new_npc(new_npc), .new_nnpc(new_nnpc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model written from the requirements
  logic [1:0]  e_mode;
  logic [8:0]  e_tt;
  logic [63:0] e_pc;

  task automatic model();
    bit hyp_tgt;
    hyp_tgt = (pstate[2] && hpstate[2]) || hyper_trap;
    e_tt = trap_type;
    if (hpstate[5] || tl == 3'd5) begin
      e_mode = 2'd2; e_pc = 64'hFFFFFFFFF00000A0;
    end else if (tl >= 3'd6) begin
      e_mode = 2'd3; e_pc = 64'd0;
    end else if (!hyp_tgt && tl > 3'd2) begin
      e_mode = 2'd1; e_tt = 9'd2;
      e_pc = (htba & ~64'h3FFF) | ((64'd2 << 5) & 64'h3FFF);
    end else if (hyp_tgt) begin
      e_mode = 2'd1;
      e_pc = (htba & ~64'h3FFF) | ((64'(trap_type) << 5) & 64'h3FFF);
    end else begin
      e_mode = 2'd0;
      e_pc = (tba & ~64'h7FFF) | ((64'(tl) + 64'd1 > 64'd1) ? 64'h4000 : 64'd0)
           | ((64'(trap_type) << 5) & 64'h3FFF);
    end
  endtask

  task automatic fire(input string req, input bit ht, input logic [2:0] t,
                      input logic [12:0] ps, input logic [11:0] hps, input logic [8:0] tt);
    logic [63:0] p_pc;
    logic [1:0]  p_mode;
    hyper_trap = ht; tl = t; pstate = ps; hpstate = hps; trap_type = tt;
    trap_valid = 1'b1;
    model();
    @(negedge clk);
    trap_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " mode"}, 64'(mode), 64'(e_mode));
    chk({req, " tt"}, 64'(eff_tt), 64'(e_tt));
    chk({req, " pc"}, new_pc, e_pc);
    chk({req, " err"}, 64'(flag_error), 64'(e_mode == 2'd3));
    if (e_mode == 2'd3) begin
      chk({req, " R4 npc"}, new_npc, 64'd0);
      chk({req, " R4 nnpc"}, new_nnpc, 64'd0);
    end else begin
      chk({req, " R10 npc"}, new_npc, e_pc + 64'd4);
      chk({req, " R10 nnpc"}, new_nnpc, e_pc + 64'd8);
    end
    // R2: idle cycle with other inputs must leave results alone
    p_pc = new_pc; p_mode = mode;
    tl = ~t; hyper_trap = ~ht; trap_type = ~tt;
    @(negedge clk);
    chk({req, " R2 idle valid"}, 64'(out_valid), 64'd0);
    chk({req, " R2 idle pc"}, new_pc, p_pc);
    chk({req, " R2 idle mode"}, 64'(mode), 64'(p_mode));
  endtask

  task automatic t_reset();
    chk("R1 valid", 64'(out_valid), 64'd0);
    chk("R1 mode", 64'(mode), 64'd0);
    chk("R1 err", 64'(flag_error), 64'd0);
    chk("R1 tt", 64'(eff_tt), 64'd0);
    chk("R1 pc", new_pc, 64'd0);
    chk("R1 npc", new_npc, 64'd0);
    chk("R1 nnpc", new_nnpc, 64'd0);
  endtask

  task automatic t_privileged();
    fire("R9 R5 user tl0", 1'b0, 3'd0, 13'h0000, 12'h000, 9'h024);
    fire("R9 priv tl1 bit14", 1'b0, 3'd1, 13'h0004, 12'h000, 9'h0C3);
    fire("R9 R7 tl2 boundary", 1'b0, 3'd2, 13'h0000, 12'h004, 9'h1FF);
  endtask

  task automatic t_hyper();
    fire("R8 R5 hyper level", 1'b0, 3'd3, 13'h1FFF, 12'h004, 9'h1FF);
    fire("R8 R6 hyper_trap user", 1'b1, 3'd1, 13'h0000, 12'h000, 9'h07E);
    fire("R6 hyper bit alone", 1'b0, 3'd0, 13'h0000, 12'h004, 9'h011);
  endtask

  task automatic t_watchdog();
    fire("R7 user tl3", 1'b0, 3'd3, 13'h0000, 12'h000, 9'h0AA);
    fire("R7 priv tl4", 1'b0, 3'd4, 13'h0004, 12'h000, 9'h155);
  endtask

  task automatic t_red();
    fire("R3 red bit", 1'b0, 3'd0, 13'h0004, 12'h020, 9'h033);
    fire("R3 tl5", 1'b1, 3'd5, 13'h0004, 12'h004, 9'h100);
    fire("R3 red over error", 1'b0, 3'd6, 13'h0000, 12'h020, 9'h001);
  endtask

  task automatic t_error();
    fire("R4 tl6", 1'b0, 3'd6, 13'h0004, 12'h004, 9'h042);
    fire("R4 tl7", 1'b1, 3'd7, 13'h0000, 12'h000, 9'h1AB);
  endtask

  initial begin
    rst = 1'b1; trap_valid = 1'b0; hyper_trap = 1'b0; tl = '0;
    pstate = '0; hpstate = '0; trap_type = '0;
    tba  = 64'h1234_5678_9ABC_DEF0;
    htba = 64'hFEDC_BA98_7654_3210;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_privileged();
    t_hyper();
    t_watchdog();
    t_red();
    t_error();
    tba  = 64'h0000_0000_0000_7FFF;
    htba = 64'hFFFF_FFFF_FFFF_C000;
    fire("R9 base low bits cleared", 1'b0, 3'd0, 13'h0000, 12'h000, 9'h1FF);
    fire("R8 base low bits cleared", 1'b1, 3'd2, 13'h0000, 12'h000, 9'h001);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule